// File: doc/BRIEF.md
# Reset Source Scope Controller

This block collects reset requests from four sources: a window watchdog, an independent watchdog, a software trigger and a reset request from the CPU. Each source has its own 2-bit scope selector. The selector decides how far the resulting reset reaches. The widest reach covers the whole system, including the PLL. The next covers the system bus, meaning the CPU, the peripherals and the clock dividers. The narrowest covers the CPU core alone. A selector can also choose no reset at all. The block drives one reset output for each of the three domains, and each generated reset lasts a fixed number of cycles.

Software reaches the block through a simple single-cycle register port. The scope selectors and the software trigger are guarded by a 32-bit unlock key. One accepted protected write spends the key, and so does any generated reset. A cause register records which sources produced a reset. Its flags are reset only by the power-on reset, so they survive the domain resets they record. Software clears them by writing ones.

Top module: `rst_scope_ctrl`

## Requirements
- R1: While and after the synchronous power-on reset `rst`, the three domain outputs are 0, the block is locked, the scope register reads 0 and the cause register reads 0x1. Bit 0 of the cause register is the power-on flag.
- R2: Word 0 is the lock register. Writing 0x51AC0FFE to it unlocks the block, and writing any other value locks it. Reading it returns 1 when unlocked and 0 when locked, with all other bits 0.
- R3: Word 1 (scope) and word 2 (software trigger) are protected. A write to either while the block is locked changes nothing. A write while unlocked takes effect, and the block is locked again from the next cycle.
- R4: In word 1, bits 9:8 select the window watchdog, bits 7:6 the independent watchdog and bits 5:4 the software trigger. For these fields, 2'b10 asserts `sys_rst`, `bus_rst` and `core_rst`, and 2'b11 asserts `bus_rst` and `core_rst`. Any other value produces no reset. Bits 3:2 and bits 31:10 read 0.
- R5: Bits 1:0 of word 1 select the CPU request. 2'b10 asserts `core_rst` only, 2'b11 asserts `bus_rst` and `core_rst`, and any other value produces no reset.
- R6: Writing 0xDEADBEEF to word 2 while unlocked raises a software reset request in that cycle. Any other value raises no request but still re-locks the block. Word 2 reads 0.
- R7: A request sampled at clock edge t drives the selected outputs high from edge t to edge t+16, which is exactly 16 cycles. While any output is high, `sys_rst` implies `bus_rst` and `bus_rst` implies `core_rst`.
- R8: When several sources fire at the same edge, the widest scope among them is applied. Whole system beats bus, and bus beats CPU core.
- R9: A request that arrives while `core_rst` is high is ignored. It neither extends nor widens the reset in progress, and it sets no cause flag.
- R10: Word 3 holds the cause flags. Bit 1 is the CPU request, bit 3 the independent watchdog, bit 4 the window watchdog and bit 5 the software trigger; bit 2 reads 0. A flag is set when its source fires with an effective scope. Writing a 1 to a flag clears it. If a set and a clear meet in the same cycle, the set wins. Generated resets leave the flags unchanged.
- R11: Every generated reset re-locks the block. If it coincides with a key write, the block ends up locked.
- R12: `bus_rdata` shows the register addressed by `bus_addr` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| win_wdg_req | input | 1 | Window watchdog reset request |
| ind_wdg_req | input | 1 | Independent watchdog reset request |
| cpu_rst_req | input | 1 | CPU reset request |
| sys_rst | output | 1 | Whole-system domain reset |
| bus_rst | output | 1 | System-bus domain reset |
| core_rst | output | 1 | CPU-core domain reset |

## Verification
Two events can fall in one cycle here. A source can fire while software writes ones to clear cause flags, and a request can arrive in the same cycle as a key write. The bench provokes the first by pulsing the CPU request together with a clear of that same flag, and expects the flag to stay set. It provokes the second by writing the unlock key in the cycle of a request, and expects the lock register to read locked afterwards. It also fires all three hardware sources together to judge the widest-scope rule, and every cycle it compares all outputs against a behavioural model.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_CORE = 2'd1,
    LVL_BUS  = 2'd2,
    LVL_SYS  = 2'd3
  } lvl_t;

  localparam int NSRC    = 4;
  localparam int SRC_CPU = 0;
  localparam int SRC_IWD = 1;
  localparam int SRC_WWD = 2;
  localparam int SRC_SW  = 3;

  localparam int CFG_W   = 10;
  localparam int CAUSE_W = 6;
  localparam logic [CFG_W-1:0]   CFG_MASK   = 10'h3F3;
  localparam logic [CAUSE_W-1:0] CAUSE_MASK = 6'h3B;

  localparam int REG_LOCK  = 0;
  localparam int REG_SCOPE = 1;
  localparam int REG_SWRST = 2;
  localparam int REG_CAUSE = 3;

  // Low bit of each source's scope field in the scope register.
  function automatic int field_lsb(input int s);
    case (s)
      SRC_CPU: field_lsb = 0;
      SRC_IWD: field_lsb = 6;
      SRC_WWD: field_lsb = 8;
      default: field_lsb = 4;
    endcase
  endfunction

  // Position of each source's flag in the cause register.
  function automatic int cause_bit(input int s);
    case (s)
      SRC_CPU: cause_bit = 1;
      SRC_IWD: cause_bit = 3;
      SRC_WWD: cause_bit = 4;
      default: cause_bit = 5;
    endcase
  endfunction

  function automatic lvl_t decode_scope(input logic [1:0] f, input logic cpu_src);
    case (f)
      2'b10:   decode_scope = cpu_src ? LVL_CORE : LVL_SYS;
      2'b11:   decode_scope = LVL_BUS;
      default: decode_scope = LVL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/rsc_regs.sv
module rsc_regs
  import rsc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter logic [DATA_W-1:0] KEY   = 32'h51AC0FFE,
  parameter logic [DATA_W-1:0] MAGIC = 32'hDEADBEEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [CAUSE_W-1:0] cause_q,
  input  logic               relock,
  output logic [DATA_W-1:0]  rdata,
  output logic               unlocked,
  output logic [CFG_W-1:0]   cfg,
  output logic               sw_hit,
  output logic [CAUSE_W-1:0] clr_mask
);
  logic wr_lock, wr_cfg, wr_sw, wr_cause;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    wr_lock  = wr && (addr == ADDR_W'(REG_LOCK));
    wr_cfg   = wr && (addr == ADDR_W'(REG_SCOPE));
    wr_sw    = wr && (addr == ADDR_W'(REG_SWRST));
    wr_cause = wr && (addr == ADDR_W'(REG_CAUSE));
    sw_hit   = wr_sw && unlocked && (wdata == MAGIC);
    clr_mask = wr_cause ? (wdata[CAUSE_W-1:0] & CAUSE_MASK) : '0;
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_W'(REG_LOCK):  rd_mux[0] = unlocked;
      ADDR_W'(REG_SCOPE): rd_mux[CFG_W-1:0] = cfg;
      ADDR_W'(REG_CAUSE): rd_mux[CAUSE_W-1:0] = cause_q;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
      cfg      <= '0;
      rdata    <= '0;
    end else begin
      rdata <= rd_mux;
      if (wr_cfg && unlocked)
        cfg <= wdata[CFG_W-1:0] & CFG_MASK;
      if (relock)
        unlocked <= 1'b0;
      else if (wr_lock)
        unlocked <= (wdata == KEY);
      else if (wr_cfg || wr_sw)
        unlocked <= 1'b0;
    end
  end
endmodule

// File: rtl/rsc_arbiter.sv
module rsc_arbiter
  import rsc_pkg::*;
(
  input  logic [NSRC-1:0]  req,
  input  logic [CFG_W-1:0] cfg,
  input  logic             busy,
  output logic [NSRC-1:0]  fire,
  output lvl_t             win
);
  lvl_t lvls [NSRC];

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign lvls[s] = decode_scope(cfg[field_lsb(s) +: 2], s == SRC_CPU);
    assign fire[s] = req[s] && !busy && (lvls[s] != LVL_NONE);
  end

  always_comb begin
    win = LVL_NONE;
    for (int s = 0; s < NSRC; s++)
      if (fire[s] && (lvls[s] > win))
        win = lvls[s];
  end
endmodule

// File: rtl/rsc_hold.sv
module rsc_hold
  import rsc_pkg::*;
#(
  parameter int HOLD_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  lvl_t start,
  output logic sys_rst,
  output logic bus_rst,
  output logic core_rst
);
  localparam int CW = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      sys_rst  <= 1'b0;
      bus_rst  <= 1'b0;
      core_rst <= 1'b0;
    end else if (core_rst) begin
      if (cnt == '0) begin
        sys_rst  <= 1'b0;
        bus_rst  <= 1'b0;
        core_rst <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (start != LVL_NONE) begin
      cnt      <= CW'(HOLD_CYC - 1);
      sys_rst  <= (start == LVL_SYS);
      bus_rst  <= (start == LVL_SYS) || (start == LVL_BUS);
      core_rst <= 1'b1;
    end
  end
endmodule

// File: rtl/rsc_causes.sv
module rsc_causes
  import rsc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    fire,
  input  logic [CAUSE_W-1:0] clr_mask,
  output logic [CAUSE_W-1:0] cause_q
);
  logic [CAUSE_W-1:0] set_v;

  always_comb begin
    set_v = '0;
    for (int s = 0; s < NSRC; s++)
      if (fire[s]) set_v[cause_bit(s)] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cause_q <= CAUSE_W'(1);
    else     cause_q <= (cause_q & ~clr_mask) | set_v;
  end
endmodule

// File: rtl/rst_scope_ctrl.sv
module rst_scope_ctrl
  import rsc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2,
  parameter int HOLD_CYC = 16,
  parameter logic [DATA_W-1:0] KEY   = 32'h51AC0FFE,
  parameter logic [DATA_W-1:0] MAGIC = 32'hDEADBEEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              win_wdg_req,
  input  logic              ind_wdg_req,
  input  logic              cpu_rst_req,
  output logic              sys_rst,
  output logic              bus_rst,
  output logic              core_rst
);
  logic               unlocked;
  logic [CFG_W-1:0]   cfg;
  logic               sw_hit;
  logic [CAUSE_W-1:0] clr_mask;
  logic [CAUSE_W-1:0] cause_q;
  logic [NSRC-1:0]    req;
  logic [NSRC-1:0]    fire;
  lvl_t               win;

  always_comb begin
    req          = '0;
    req[SRC_CPU] = cpu_rst_req;
    req[SRC_IWD] = ind_wdg_req;
    req[SRC_WWD] = win_wdg_req;
    req[SRC_SW]  = sw_hit;
  end

  rsc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .KEY(KEY), .MAGIC(MAGIC)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .cause_q(cause_q), .relock(win != LVL_NONE), .rdata(bus_rdata),
    .unlocked(unlocked), .cfg(cfg), .sw_hit(sw_hit), .clr_mask(clr_mask)
  );

  rsc_arbiter u_arb (
    .req(req), .cfg(cfg), .busy(core_rst), .fire(fire), .win(win)
  );

  rsc_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst(rst), .start(win),
    .sys_rst(sys_rst), .bus_rst(bus_rst), .core_rst(core_rst)
  );

  rsc_causes u_causes (
    .clk(clk), .rst(rst), .fire(fire), .clr_mask(clr_mask), .cause_q(cause_q)
  );
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
  parameter int ADDR_W   = 2,
  parameter int HOLD_CYC = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              sys_rst,
  input logic              bus_rst,
  input logic              core_rst,
  input logic              unlocked,
  input logic [5:0]        cause
);
  localparam int HW = $clog2(HOLD_CYC + 1) + 1;
  logic [HW-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (rst)           hold_cnt <= '0;
    else if (core_rst) hold_cnt <= hold_cnt + 1'b1;
    else               hold_cnt <= '0;
  end

  assert_poweron_R1: assert property (@(posedge clk)
    rst |=> (cause == 6'h01 && !core_rst && !unlocked));

  assert_sys_bus_R4: assert property (@(posedge clk) disable iff (rst)
    sys_rst |-> bus_rst);

  assert_bus_core_R5: assert property (@(posedge clk) disable iff (rst)
    bus_rst |-> core_rst);

  assert_hold_max_R7: assert property (@(posedge clk) disable iff (rst)
    core_rst |-> (hold_cnt < HW'(HOLD_CYC)));

  assert_hold_len_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst) |-> (hold_cnt == HW'(HOLD_CYC)));

  assert_relock_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(core_rst) |-> !unlocked);

  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == ADDR_W'(3)) |=> ((cause & $past(cause)) == $past(cause)));
endmodule

bind rst_scope_ctrl rsc_checker #(.ADDR_W(ADDR_W), .HOLD_CYC(HOLD_CYC)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .sys_rst(sys_rst), .bus_rst(bus_rst), .core_rst(core_rst),
  .unlocked(unlocked), .cause(cause_q)
);

// File: tb/sim_rst_scope_ctrl.sv
`timescale 1ns/1ps
module sim_rst_scope_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        win_wdg_req = 1'b0, ind_wdg_req = 1'b0, cpu_rst_req = 1'b0;
  logic        sys_rst, bus_rst, core_rst;

  always #2.5 clk = ~clk;

  rst_scope_ctrl u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .win_wdg_req(win_wdg_req), .ind_wdg_req(ind_wdg_req), .cpu_rst_req(cpu_rst_req),
    .sys_rst(sys_rst), .bus_rst(bus_rst), .core_rst(core_rst)
  );

  // behavioural reference model
  int          n_cmp = 0, n_bad = 0, cyc = 0;
  bit          started = 0, done = 0;
  string       ph = "R1";
  bit          m_unl;
  logic [9:0]  m_scope;
  logic [5:0]  m_cause;
  int          m_left;
  logic        m_sys, m_bus, m_core;
  logic [31:0] m_rdata;

  function automatic int lvl_of(input logic [1:0] f, input bit cpu);
    if (f == 2'b10) return cpu ? 1 : 3;
    if (f == 2'b11) return 2;
    return 0;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_unl = 0; m_scope = 0; m_cause = 6'h01; m_left = 0;
      m_sys = 0; m_bus = 0; m_core = 0; m_rdata = 0;
    end else begin
      int best;
      bit sw, f_cpu, f_ind, f_win, f_sw;
      logic [5:0] clr;
      case (bus_addr)
        2'd0: m_rdata = {31'd0, m_unl};
        2'd1: m_rdata = {22'd0, m_scope};
        2'd3: m_rdata = {26'd0, m_cause};
        default: m_rdata = 32'd0;
      endcase
      sw    = bus_wr && bus_addr == 2 && m_unl && bus_wdata == 32'hDEADBEEF;
      f_cpu = !m_core && cpu_rst_req && lvl_of(m_scope[1:0], 1) > 0;
      f_ind = !m_core && ind_wdg_req && lvl_of(m_scope[7:6], 0) > 0;
      f_win = !m_core && win_wdg_req && lvl_of(m_scope[9:8], 0) > 0;
      f_sw  = !m_core && sw && lvl_of(m_scope[5:4], 0) > 0;
      best = 0;
      if (f_cpu && lvl_of(m_scope[1:0], 1) > best) best = lvl_of(m_scope[1:0], 1);
      if (f_ind && lvl_of(m_scope[7:6], 0) > best) best = lvl_of(m_scope[7:6], 0);
      if (f_win && lvl_of(m_scope[9:8], 0) > best) best = lvl_of(m_scope[9:8], 0);
      if (f_sw  && lvl_of(m_scope[5:4], 0) > best) best = lvl_of(m_scope[5:4], 0);
      clr = (bus_wr && bus_addr == 3) ? bus_wdata[5:0] : 6'd0;
      m_cause = m_cause & ~clr;
      if (f_cpu) m_cause[1] = 1;
      if (f_ind) m_cause[3] = 1;
      if (f_win) m_cause[4] = 1;
      if (f_sw)  m_cause[5] = 1;
      if (bus_wr && bus_addr == 1 && m_unl) m_scope = bus_wdata[9:0] & 10'h3F3;
      if (best > 0) m_unl = 0;
      else if (bus_wr && bus_addr == 0) m_unl = (bus_wdata == 32'h51AC0FFE);
      else if (bus_wr && (bus_addr == 1 || bus_addr == 2)) m_unl = 0;
      if (m_core) begin
        if (m_left == 0) begin m_sys = 0; m_bus = 0; m_core = 0; end
        else m_left--;
      end else if (best > 0) begin
        m_left = 15; m_sys = (best == 3); m_bus = (best >= 2); m_core = 1;
      end
    end
  end

  task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", ph, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      cyc++;
      cmp("sys_rst", {31'd0, sys_rst}, {31'd0, m_sys});
      cmp("bus_rst", {31'd0, bus_rst}, {31'd0, m_bus});
      cmp("core_rst", {31'd0, core_rst}, {31'd0, m_core});
      cmp("bus_rdata", bus_rdata, m_rdata);
      if (cyc > 20000) begin
        n_bad++; done = 1;
        $display("FAIL watchdog: run did not end, actual %0d cycles expected <= 20000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  task automatic drive(input logic w, input logic [1:0] a, input logic [31:0] d,
                       input logic [2:0] r);
    bus_wr = w; bus_addr = a; bus_wdata = d;
    {win_wdg_req, ind_wdg_req, cpu_rst_req} = r;
    @(posedge clk); #1;
    bus_wr = 0; {win_wdg_req, ind_wdg_req, cpu_rst_req} = 3'b000;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    drive(1, a, d, 3'b000);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 2'(i), 32'd0, 3'b000);
  endtask

  localparam logic [31:0] KEYV = 32'h51AC0FFE;

  initial begin
    repeat (3) @(posedge clk);
    #1; rst = 0;
    ph = "R1";  idle(8);
    ph = "R3";  wr(1, 32'h300); idle(4);
    ph = "R2";  wr(0, KEYV); idle(4); wr(0, 32'h1234); idle(4); wr(0, KEYV);
    ph = "R4";  wr(1, 32'hFFFF_FEF2); idle(4);            // reserved bits dropped
    ph = "R12"; wr(0, KEYV); wr(1, 32'h2F2); idle(8);     // win=sys ind=bus sw=bus cpu=core
    ph = "R5";  drive(0, 3, 0, 3'b001); idle(20);
    ph = "R4";  drive(0, 3, 0, 3'b010); idle(20);
    ph = "R7";  drive(0, 3, 0, 3'b100); idle(20);
    ph = "R9";  drive(0, 3, 0, 3'b001); idle(5); drive(0, 3, 0, 3'b110); idle(20);
    ph = "R8";  drive(0, 3, 0, 3'b111); idle(20);
    ph = "R10"; wr(3, 32'hFFFF_FFFF); idle(4);
    ph = "R6";  wr(0, KEYV); wr(2, 32'h1234_5678); idle(4);
    wr(2, 32'hDEADBEEF); idle(4);                          // locked: ignored
    wr(0, KEYV); wr(2, 32'hDEADBEEF); idle(20);
    ph = "R10"; drive(1, 3, 32'h2, 3'b001); idle(20);      // set beats clear
    ph = "R11"; wr(0, KEYV); drive(0, 0, 0, 3'b001); idle(20);
    drive(1, 0, KEYV, 3'b001); idle(20);
    ph = "R5";  wr(0, KEYV); wr(1, 32'h0F3); idle(4);      // cpu=11 -> bus
    drive(0, 3, 0, 3'b001); idle(20);
    ph = "R4";  wr(0, KEYV); wr(1, 32'h151); idle(4);      // all ineffective
    drive(0, 3, 0, 3'b111); wr(0, KEYV); wr(2, 32'hDEADBEEF); idle(20);
    ph = "R1";  wr(0, KEYV); wr(1, 32'h200); drive(0, 3, 0, 3'b100); idle(3);
    rst = 1; idle(3); rst = 0; idle(8);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule